// File: doc/BRIEF.md
# Directional Track Switch for a Mesh Routing Tile

This block is the switch point at the corner of one tile in a mesh routing fabric. Four channels meet there: north, east, south and west. All four channels have the same width `W`. Every wire is directional: on each side, `W/2` tracks enter the switch and `W/2` tracks leave it. Each leaving track has exactly one driver, which is a small configurable multiplexer, so no wire is ever shared and there are no tristate drivers.

The connection pattern is disjoint. Leaving track `t` on a side can take its value only from entering track `t` of one of the other three sides. It can also be switched off, which drives it to 0. As a result, every entering track can reach exactly three leaving tracks, one on each other side. From the data inputs to the outputs the switch is purely combinational.

The multiplexer selects are loaded through a serial shift chain. The chain shifts while `cfg_en` is high. During that time every output track is forced to 0, so partial configurations never reach the fabric. Once `cfg_en` falls, the loaded pattern stays in place until the next load or reset.

Top module: `xbar_tile_switch`

## Requirements
- R1: After reset every select code is 0. While reset is held and on release, `trk_out` is all zeros and `cfg_dout` is 0, whatever `trk_in` carries.
- R2: `W` is even and at least 2, and an odd or smaller value stops elaboration. Each side has `W/2` entering and `W/2` leaving tracks. Side `s` (north=0, east=1, south=2, west=3) occupies bits `[s*W/2 +: W/2]` of `trk_in` and of `trk_out`.
- R3: The chain holds `4*W` bits. On each rising clock edge with `cfg_en` high, `cfg_din` enters bit 0 and every bit moves up one place. `cfg_dout` always shows bit `4*W-1`, so the first bit shifted in is the first to come out after a full load.
- R4: Leaving track `t` of side `s` takes its 2-bit select from chain bits `[2*(s*W/2+t)+1 : 2*(s*W/2+t)]`. A full load therefore sends the select of west track `W/2-1` first and the select of north track 0 last.
- R5: Select code 0 drives the leaving track to 0.
- R6: Select code `k` of 1, 2 or 3 on leaving track `t` of side `s` passes entering track `t` of side `(s+k) mod 4`. So code 1 takes the next side clockwise, code 2 the opposite side and code 3 the next side counter-clockwise.
- R7: While `cfg_en` is high, every bit of `trk_out` is 0, whatever the inputs and selects are.
- R8: While `cfg_en` is low, the chain and the selects keep their values, whatever `cfg_din` does.
- R9: With `cfg_en` low, `trk_out` follows `trk_in` without waiting for a clock edge.
- R10: Each entering track can drive exactly three leaving tracks. These are the tracks with the same index on the three other sides, and never a track on its own side or with another index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low asynchronous reset, clears all selects |
| cfg_en | input | 1 | Shift enable for the chain; also forces all outputs to 0 |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (top bit of the chain) |
| trk_in | input | 2*W | Entering tracks, `W/2` per side, north side at the low bits |
| trk_out | output | 2*W | Leaving tracks, `W/2` per side, north side at the low bits |

## Verification
The hardest property to reach from the ports is fan-out isolation: an entering track must show up on exactly three leaving tracks, on three distinct foreign sides, with the same index. A single configuration can expose at most one of those paths per leaving track. The stimulus therefore loads the three uniform configurations (every select set to 1, then to 2, then to 3) and drives every one-hot input pattern under each. For every entering track it collects the set of sides that lit up and then checks that set. Placing a select field correctly inside the long chain is the other situation that is hard to see from the ports. A mixed per-track code pattern, followed by streaming a known word through `cfg_dout`, exposes field and shift-order errors.

// File: rtl/tile_switch_pkg.sv
package tile_switch_pkg;

  typedef enum logic [1:0] {
    SIDE_NORTH = 2'd0,
    SIDE_EAST  = 2'd1,
    SIDE_SOUTH = 2'd2,
    SIDE_WEST  = 2'd3
  } side_e;

  localparam int NUM_SIDES = 4;
  localparam int SEL_W     = 2;
  localparam int NUM_CAND  = 3;

  // side feeding leaving side `out_side` for select code `code` (1..3)
  function automatic int src_side(input int out_side, input int code);
    return (out_side + code) % NUM_SIDES;
  endfunction

  // lowest chain bit of the select field for (side, track)
  function automatic int sel_lsb(input int side, input int track, input int half);
    return SEL_W * (side * half + track);
  endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
  parameter int LEN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] q,
  output logic           dout
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[LEN-2:0], din};
    end
  end

  assign dout = q[LEN-1];

endmodule

// File: rtl/track_mux.sv
module track_mux (
  input  logic [2:0] cand,
  input  logic [1:0] sel,
  input  logic       blank,
  output logic       y
);

  always_comb begin
    if (blank) begin
      y = 1'b0;
    end else begin
      unique case (sel)
        2'd1:    y = cand[0];
        2'd2:    y = cand[1];
        2'd3:    y = cand[2];
        default: y = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/xbar_tile_switch.sv
module xbar_tile_switch
  import tile_switch_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_din,
  output logic           cfg_dout,
  input  logic [2*W-1:0] trk_in,
  output logic [2*W-1:0] trk_out
);

  localparam int HALF    = W / 2;
  localparam int NOUT    = NUM_SIDES * HALF;
  localparam int CFG_LEN = SEL_W * NOUT;

  if ((W < 2) || ((W % 2) != 0)) begin : g_bad_width
    $error("xbar_tile_switch: W must be even and at least 2");
  end

  // full select image, exposed for the checker
  logic [CFG_LEN-1:0] sel_flat;

  cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .q        (sel_flat),
    .dout     (cfg_dout)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    for (genvar t = 0; t < HALF; t++) begin : g_trk
      localparam int OIDX = s * HALF + t;
      localparam int LSB  = sel_lsb(s, t, HALF);
      logic [NUM_CAND-1:0] cand;
      for (genvar k = 1; k <= NUM_CAND; k++) begin : g_cand
        assign cand[k-1] = trk_in[src_side(s, k) * HALF + t];
      end
      track_mux u_mux (
        .cand  (cand),
        .sel   (sel_flat[LSB +: SEL_W]),
        .blank (cfg_en),
        .y     (trk_out[OIDX])
      );
    end
  end

endmodule

// File: rtl/tile_switch_chk.sv
module tile_switch_chk
  import tile_switch_pkg::*;
#(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_en,
  input logic                 cfg_din,
  input logic                 cfg_dout,
  input logic [2*W-1:0]       trk_in,
  input logic [2*W-1:0]       trk_out,
  input logic [4*W-1:0]       sel_flat
);

  localparam int HALF = W / 2;
  localparam int LEN  = 4 * W;

  // R7: outputs blanked during configuration
  a_r7_blank_in_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> (trk_out == '0));

  // R3: serial input lands in bit 0, rest moves up
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (sel_flat[0] == $past(cfg_din)));

  a_r3_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (sel_flat[LEN-1:1] == $past(sel_flat[LEN-2:0])));

  a_r3_dout_top: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dout == sel_flat[LEN-1]);

  // R8: configuration holds while idle
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(sel_flat));

  for (genvar s = 0; s < 4; s++) begin : g_s
    for (genvar t = 0; t < HALF; t++) begin : g_t
      localparam int O  = s * HALF + t;
      localparam int I1 = ((s + 1) % 4) * HALF + t;
      localparam int I2 = ((s + 2) % 4) * HALF + t;
      localparam int I3 = ((s + 3) % 4) * HALF + t;
      localparam int LS = 2 * O;
      // R5: code 0 gives a quiet track
      a_r5_off: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_flat[LS +: 2] == 2'd0) |-> !trk_out[O]);
      // R10: a high output needs a high same-index input on another side
      a_r10_source: assert property (@(posedge clk) disable iff (!rst_n)
        trk_out[O] |-> (trk_in[I1] || trk_in[I2] || trk_in[I3]));
    end
  end

endmodule

bind xbar_tile_switch tile_switch_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_en   (cfg_en),
  .cfg_din  (cfg_din),
  .cfg_dout (cfg_dout),
  .trk_in   (trk_in),
  .trk_out  (trk_out),
  .sel_flat (sel_flat)
);

// File: tb/xbar_tile_switch_test.sv
`timescale 1ns/1ps
module xbar_tile_switch_test;

  localparam int W  = 8;
  localparam int H  = W / 2;
  localparam int NO = 4 * H;
  localparam int CL = 2 * NO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 1'b0;
  logic          cfg_din = 1'b0;
  logic          cfg_dout;
  logic [NO-1:0] trk_in = '0;
  logic [NO-1:0] trk_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  xbar_tile_switch #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .trk_in(trk_in), .trk_out(trk_out)
  );

  task automatic chk(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // expected outputs: rotate whole side vectors by the code, per track
  function automatic logic [NO-1:0] model(input logic [CL-1:0] cfg, input logic [NO-1:0] din);
    logic [NO-1:0] r = '0;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < H; t++) begin
        int code = cfg[2*(s*H+t) +: 2];
        if (code != 0) r[s*H+t] = din[((s + code) & 3) * H + t];
      end
    end
    return r;
  endfunction

  task automatic load(input logic [CL-1:0] v);
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = CL - 1; i >= 0; i--) begin
      cfg_din = v[i];
      #1 chk("R7 blank while loading", trk_out, '0);
      @(posedge clk);
      @(negedge clk);
    end
    cfg_en  = 1'b0;
    cfg_din = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CL-1:0] cfg;
    logic [3:0]    reach [NO];
    logic [NO-1:0] lfsr;
    logic [CL-1:0] pat;

    // R1 reset state
    trk_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs in reset", trk_out, '0);
    chk("R1 cfg_dout in reset", {{(NO-1){1'b0}}, cfg_dout}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", trk_out, '0);

    // R2 port width follows W
    chk("R2 width", NO[NO-1:0], (2 * W) & {NO{1'b1}});

    for (int b = 0; b < NO; b++) reach[b] = '0;

    // uniform codes, one-hot sweep: R5 R6 R9 R10
    for (int k = 0; k < 4; k++) begin
      cfg = {NO{k[1:0]}};
      trk_in = '1;
      load(cfg);
      for (int b = 0; b < NO; b++) begin
        trk_in = NO'(1) << b;
        #1;
        chk(k == 0 ? "R5 code off" : "R6 source pick (R9 no clock)", trk_out, model(cfg, trk_in));
        if (k != 0) begin
          chk("R10 one path per code", NO'($countones(trk_out)), NO'(1));
          for (int o = 0; o < NO; o++) if (trk_out[o]) reach[b][o / H] = 1'b1;
        end
      end
      trk_in = '1;
      #1 chk("R6 all ones", trk_out, model(cfg, trk_in));
    end
    for (int b = 0; b < NO; b++) begin
      logic [3:0] want;
      want = 4'hF;
      want[b / H] = 1'b0;
      chk("R10 reach set", NO'(reach[b]), NO'(want));
    end

    // mixed per-track codes: R4 field layout
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < H; t++)
        cfg[2*(s*H+t) +: 2] = 2'((s + t + 1) % 4);
    load(cfg);
    lfsr = 16'hACE1;
    for (int n = 0; n < 64; n++) begin
      lfsr = {lfsr[NO-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      trk_in = lfsr;
      #1 chk("R4 mixed fields", trk_out, model(cfg, trk_in));
    end

    // R8: idle chain ignores cfg_din
    trk_in = 16'h5A3C;
    for (int n = 0; n < 20; n++) begin
      cfg_din = n[0];
      @(posedge clk);
      @(negedge clk);
    end
    chk("R8 selects kept", trk_out, model(cfg, trk_in));
    chk("R8 dout kept", {{(NO-1){1'b0}}, cfg_dout}, {{(NO-1){1'b0}}, cfg[CL-1]});

    // R3: stream a word through the chain
    pat = 32'hC35A96E1;
    load(pat);
    chk("R3 dout after load", {{(NO-1){1'b0}}, cfg_dout}, {{(NO-1){1'b0}}, pat[CL-1]});
    cfg_en = 1'b1;
    cfg_din = 1'b0;
    trk_in = '1;
    for (int i = 0; i < CL; i++) begin
      #1;
      chk("R3 shift out order", {{(NO-1){1'b0}}, cfg_dout}, {{(NO-1){1'b0}}, pat[CL-1-i]});
      chk("R7 blank while shifting", trk_out, '0);
      @(posedge clk);
      @(negedge clk);
    end
    cfg_en = 1'b0;
    #1 chk("R5 chain cleared", trk_out, '0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule